// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel with a small word-addressed register window. Software programs a limit value and a control byte. The channel then counts down from the limit at a rate taken from a clock-enable input, optionally slowed by a divide-by-16 or divide-by-256 prescaler. When the count passes from one to zero, a sticky raw interrupt flag is set. A maskable interrupt line follows that flag when the interrupt-enable bit is set.

The channel has three modes: periodic reload, one-shot, and free-running. Free-running mode ignores the programmed limit and wraps through the whole counter range. The counter can be 16 or 32 bits wide, chosen at run time. Two registers store the limit. The first restarts the count at once. The second updates only the stored limit, which the counter picks up at its next natural reload. Writes take effect on the clock edge at which `wr_en` is sampled high. Reads are combinational from `addr`.

Top module: `interval_timer`

## Requirements
- R1: After reset the control byte reads 0x20 (interrupt enable only, timer stopped), the raw flag reads 0, the interrupt output is low, and the count reads 0.
- R2: Register word addresses: 0 immediate limit, 1 count value, 2 control, 3 interrupt clear, 4 raw status (bit 0), 5 masked status (bit 0), 6 background limit. Addresses 0 and 6 both read the stored limit. Address 2 reads the control byte zero-extended. Addresses 3 and 7 read 0.
- R3: Control bits [3:2] select the prescale. 00 gives one count step per `tick_en` cycle, 01 one step per 16, and 10 one step per 256. Any control write restarts the prescale phase.
- R4: Periodic mode (control bit 6 = 1, bit 0 = 0): each step decrements the count. The step that takes the count from 1 to 0 sets the raw flag. The step after that reloads the limit.
- R5: One-shot mode (control bit 0 = 1): the count decrements to 0, sets the raw flag, and then holds at 0.
- R6: Free-running mode (control bits 6 and 0 both 0): the reload value is 0xFFFFFFFF in 32-bit size and 0x0000FFFF in 16-bit size, whatever the stored limit.
- R7: Control bit 1 = 0 selects 16-bit size. Only the low 16 bits of the limit are used, and the count reads with its upper 16 bits zero.
- R8: A write to address 0 stores the limit and reloads the count in the same edge. A write to address 6 stores the limit without touching the count.
- R9: Writes to address 1 have no effect on the count.
- R10: Any write to address 3 clears the raw flag. An expiry in the same cycle takes precedence and leaves the flag set.
- R11: The masked status and the `irq` output equal the raw flag AND control bit 5.
- R12: Control bit 7 enables counting. A control write that sets bit 7 while it was clear reloads the count from the effective limit. While bit 7 is clear, the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-rate enable, one pulse per base tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps periodic and one-shot modes across all three prescale settings, both counter sizes and several limits. It checks the count and the flags at step counts just before, at and after expiry. This targets an off-by-one in the reload point, which would shift the count by one, and a one-shot that reloads instead of holding. It runs the 16-bit free-running counter through a full wrap. A design that used the stored limit, or kept the upper bits, would read a wrong reload value there. The bench also checks a background limit that must not disturb the running count, an interrupt clear that coincides with expiry, a write to the read-only value register, and a prescaler phase that a control rewrite must restart. A design that got any of these wrong would show a count one step off, or a lost or stuck flag.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ICLR   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_BGLOAD = 3'd6;

  // control byte, most significant field first
  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] pre;       // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/itmr_prediv.sv
module itmr_prediv #(
  parameter int unsigned PW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         run,
  input  logic         restart,
  input  logic [1:0]   sel,
  output logic         step
);
  localparam int unsigned MID = PW / 2;

  logic [PW-1:0] div_q, div_d;
  logic [PW-1:0] mask;

  always_comb begin
    unique case (sel)
      2'b01:   mask = {{(PW-MID){1'b0}}, {MID{1'b1}}};
      2'b10:   mask = {PW{1'b1}};
      default: mask = '0;
    endcase
  end

  assign step = run && tick_en && !restart && ((div_q & mask) == mask);

  always_comb begin
    if (restart || !run)  div_d = '0;
    else if (tick_en)     div_d = div_q + 1'b1;
    else                  div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/itmr_count.sv
module itmr_count #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          oneshot,
  input  logic          wide,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  localparam logic [DW-1:0] NARROW_MASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  logic [DW-1:0] cnt_q, cnt_d, size_mask;

  assign size_mask = wide ? {DW{1'b1}} : NARROW_MASK;
  assign cnt       = cnt_q & size_mask;
  assign expire    = step && !load && (cnt == {{(DW-1){1'b0}}, 1'b1});

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      if (cnt == '0) cnt_d = oneshot ? cnt_q : load_val;
      else           cnt_d = (cnt - 1'b1) & size_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 16,
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [DW-1:0] NARROW_ONES = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] lim_q, lim_d;
  logic          raw_q, raw_d;

  logic wr_load, wr_ctrl, wr_iclr, wr_bg;
  logic [DW-1:0] eff_lim, cnt_w;
  logic load_now, step_w, exp_w;

  assign wr_load = wr_en && (addr == ADR_LOAD);
  assign wr_ctrl = wr_en && (addr == ADR_CTRL);
  assign wr_iclr = wr_en && (addr == ADR_ICLR);
  assign wr_bg   = wr_en && (addr == ADR_BGLOAD);

  // next-state of the programmable registers
  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(wdata[7:0]) : ctrl_q;
    lim_d  = (wr_load || wr_bg) ? wdata : lim_q;
  end

  // effective reload value from the values in force after this edge
  always_comb begin
    if (!ctrl_d.periodic && !ctrl_d.oneshot)
      eff_lim = ctrl_d.wide ? {DW{1'b1}} : NARROW_ONES;
    else
      eff_lim = ctrl_d.wide ? lim_d : (lim_d & NARROW_ONES);
  end

  assign load_now = wr_load || (wr_ctrl && ctrl_d.run && !ctrl_q.run);

  itmr_prediv #(.PW(PW)) prediv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (ctrl_q.run),
    .restart (wr_ctrl),
    .sel     (ctrl_q.pre),
    .step    (step_w)
  );

  itmr_count #(.DW(DW), .NW(NW)) count_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step_w),
    .load     (load_now),
    .load_val (eff_lim),
    .oneshot  (ctrl_q.oneshot),
    .wide     (ctrl_q.wide),
    .cnt      (cnt_w),
    .expire   (exp_w)
  );

  // expiry wins over a clear in the same cycle
  always_comb begin
    if (exp_w)        raw_d = 1'b1;
    else if (wr_iclr) raw_d = 1'b0;
    else              raw_d = raw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      lim_q  <= '0;
      raw_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      lim_q  <= lim_d;
      raw_q  <= raw_d;
    end
  end

  assign irq = raw_q && ctrl_q.ie;

  always_comb begin
    unique case (addr)
      ADR_LOAD, ADR_BGLOAD: rdata = lim_q;
      ADR_VALUE:            rdata = cnt_w;
      ADR_CTRL:             rdata = {{(DW-8){1'b0}}, ctrl_q};
      ADR_RAW:              rdata = {{(DW-1){1'b0}}, raw_q};
      ADR_MASKED:           rdata = {{(DW-1){1'b0}}, raw_q & ctrl_q.ie};
      default:              rdata = '0;
    endcase
  end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [DW-1:0] cnt,
  input logic          raw,
  input logic          step,
  input logic          expire,
  input logic          oneshot
);

  assert_masked_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd5) |-> (rdata[0] == irq));

  assert_value_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd1 && !step) |=> $stable(cnt));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && !expire) |=> !raw);

  assert_expire_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw);

  assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && cnt == '0 && !wr_en) |=> (cnt == '0));

endmodule

bind interval_timer interval_timer_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq     (irq),
  .cnt     (cnt_w),
  .raw     (raw_q),
  .step    (step_w),
  .expire  (exp_w),
  .oneshot (ctrl_q.oneshot)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, v); chk("R1 ctrl", v, 32'h20);
    rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(3'd1, v); chk("R1 value", v, 0);
    ticks(5);
    rd(3'd1, v); chk("R12 disabled holds", v, 0);

    // R6 free-running 32-bit ignores limit
    wr(3'd0, 32'd5);
    wr(3'd2, 32'h82);
    rd(3'd1, v); chk("R6 free32 reload", v, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 load readback", v, 32'd5);
    ticks(3);
    rd(3'd1, v); chk("R6 free32 count", v, 32'hFFFF_FFFC);

    // R6/R7 free-running 16-bit full wrap
    wr(3'd2, 32'h00);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hA0);
    rd(3'd1, v); chk("R7 free16 reload", v, 32'h0000_FFFF);
    ticks(65534);
    rd(3'd1, v); chk("R7 free16 near end", v, 32'd1);
    rd(3'd4, v); chk("R4 raw before expiry", v, 0);
    ticks(1);
    rd(3'd1, v); chk("R7 free16 zero", v, 0);
    rd(3'd4, v); chk("R4 raw at expiry", v, 1);
    chk("R11 irq with ie", {31'b0, irq}, 1);
    ticks(1);
    rd(3'd1, v); chk("R6 free16 wrap", v, 32'h0000_FFFF);

    // R11 masking, R12 no reload without enable rise
    wr(3'd2, 32'h80);
    rd(3'd1, v); chk("R12 no reload when already on", v, 32'h0000_FFFF);
    chk("R11 irq masked", {31'b0, irq}, 0);
    rd(3'd5, v); chk("R11 masked status", v, 0);
    rd(3'd4, v); chk("R11 raw kept", v, 1);
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd4, v); chk("R10 clear", v, 0);

    // R9 value write ignored, R2 unused address
    wr(3'd1, 32'h1234);
    rd(3'd1, v); chk("R9 value write ignored", v, 32'h0000_FFFF);
    rd(3'd7, v); chk("R2 unused reads zero", v, 0);
    rd(3'd3, v); chk("R2 clear reads zero", v, 0);

    // R8 immediate vs background limit
    wr(3'd2, 32'h00);
    wr(3'd6, 32'd10);
    wr(3'd2, 32'hE2);
    rd(3'd1, v); chk("R12 enable reload", v, 32'd10);
    ticks(3);
    rd(3'd1, v); chk("R4 periodic count", v, 32'd7);
    wr(3'd0, 32'd20);
    rd(3'd1, v); chk("R8 load immediate", v, 32'd20);
    wr(3'd6, 32'd2);
    rd(3'd1, v); chk("R8 bgload no effect on count", v, 32'd20);
    rd(3'd0, v); chk("R2 load reads bg limit", v, 32'd2);
    rd(3'd6, v); chk("R2 bgload readback", v, 32'd2);
    ticks(20);
    rd(3'd1, v); chk("R4 reached zero", v, 0);
    rd(3'd4, v); chk("R4 raw set", v, 1);
    ticks(1);
    rd(3'd1, v); chk("R8 bg limit at reload", v, 32'd2);

    // R7 narrow limit masking
    wr(3'd2, 32'h00);
    wr(3'd0, 32'h0001_2345);
    wr(3'd2, 32'hC0);
    rd(3'd1, v); chk("R7 narrow limit", v, 32'h0000_2345);
    rd(3'd2, v); chk("R2 ctrl readback", v, 32'hC0);

    // R10 expiry beats clear in the same cycle
    wr(3'd2, 32'h00);
    wr(3'd3, 32'h0);
    wr(3'd6, 32'd1);
    wr(3'd2, 32'hC0);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; addr = 3'd3; wdata = 0;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(3'd4, v); chk("R10 expiry wins over clear", v, 1);

    // R3 control write restarts prescale phase
    wr(3'd2, 32'h00);
    wr(3'd6, 32'd4);
    wr(3'd2, 32'hC4);
    ticks(10);
    wr(3'd2, 32'hC4);
    ticks(10);
    rd(3'd1, v); chk("R3 prescale restart", v, 32'd4);
    ticks(6);
    rd(3'd1, v); chk("R3 prescale sixteen", v, 32'd3);

    // sweep: mode x prescale x size/limit x step count
    for (int mode = 0; mode < 2; mode++) begin
      for (int pre = 0; pre < 3; pre++) begin
        for (int li = 0; li < 2; li++) begin
          int lim = (li == 1) ? 4 : 1;
          int div = (pre == 0) ? 1 : (pre == 1) ? 16 : 256;
          int ks[5];
          ks[0] = 0; ks[1] = lim - 1; ks[2] = lim; ks[3] = lim + 1; ks[4] = 2 * lim + 1;
          for (int ki = 0; ki < 5; ki++) begin
            int k = ks[ki];
            int ie = ki % 2;
            logic [31:0] c, ev, er, stored;
            c = 32'h80 | ((mode == 0) ? 32'h40 : 32'h01) | (pre << 2) | (li << 1) | (ie << 5);
            stored = (li == 1) ? lim : (32'h0001_0000 | lim);
            wr(3'd2, 32'h00);
            wr(3'd3, 32'h0);
            wr(3'd6, stored);
            wr(3'd2, c);
            ticks(k * div + div - 1);
            if (mode == 0) ev = lim - (k % (lim + 1));
            else           ev = (k >= lim) ? 0 : lim - k;
            er = (k >= lim) ? 1 : 0;
            rd(3'd1, v);
            chk(mode == 0 ? "R4 R3 sweep value" : "R5 R3 sweep value", v, ev);
            rd(3'd4, v); chk("R4 sweep raw", v, er);
            rd(3'd5, v); chk("R11 sweep masked", v, er & ie);
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule